// File: doc/BRIEF.md
# Core Timer Fractional Prescaler

This block makes the time base for a 64-bit free-running counter that all cores in a cluster read. Two input sources arrive as single-cycle enable pulses in one clock domain: a crystal reference and a bus clock. A control register picks the source and the size of each counter step, which is one or two. A 32-bit prescaler register sets the rate. The block emits one tick for every P/2^31 selected input pulses, where P is the prescaler value. A value of 0x80000000 therefore gives one tick per pulse.

Software programs both registers through a plain write port and reads them back through a combinational read port. The block drives the counter value and a one-cycle tick strobe. Per-core compare timers use that strobe and are not part of this block.

The rate comes from a phase accumulator. Each selected pulse adds 2^31 to it. When the sum reaches P, a tick is issued and P is subtracted. The tick stream is therefore as evenly spaced as the ratio allows.

Top module: `ctm_core_timer`

## Requirements
- R1: After a synchronous active-low reset, the counter is 0, the tick strobe is low, and reads of the control register (offset 0x000) and the prescaler register (offset 0x008) return 0.
- R2: Control register, offset 0x000: bit 8 is the source select and bit 9 is the step select. Only these two bits are stored. Reads return them in place and every other bit reads as 0.
- R3: Prescaler register, offset 0x008: holds all 32 written bits and reads them back. Any other offset reads as 0, and writes to any other offset change neither register.
- R4: With source select 0, only crystal pulses (`xtal_pulse`) advance the rate logic. With source select 1, only bus pulses (`bus_pulse`) do. Pulses on the unselected source have no effect on tick or counter.
- R5: With a prescaler value from 1 to 0x80000000 inclusive, every selected pulse gives a tick in the following cycle.
- R6: With a prescaler value P above 0x80000000, each selected pulse adds 2^31 to an accumulator that starts at 0. When the sum is at least P, a tick is issued and the accumulator keeps the sum minus P. Otherwise the accumulator keeps the sum. The tick rate is therefore pulse rate × 2^31 / P.
- R7: A prescaler value of 0 gives no ticks. The counter and the accumulator hold their values.
- R8: The tick strobe is high for one cycle, in the cycle after the pulse that causes it. The counter advances at the same edge, by 1 when step select is 0 and by 2 when it is 1, wrapping modulo 2^64.
- R9: A register write in the same cycle as a selected pulse takes effect after that edge. The source, step and prescaler values held before the write govern that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; both sources are enable pulses in this domain |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_pulse | input | 1 | One-cycle enable per crystal reference edge |
| bus_pulse | input | 1 | One-cycle enable per bus clock edge |
| cfg_wr | input | 1 | Register write strobe |
| cfg_waddr | input | 8 | Byte offset of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 8 | Byte offset of the combinational read |
| cfg_rdata | output | 32 | Read data |
| tick | output | 1 | One-cycle strobe per counter advance |
| count | output | 64 | Free-running counter value |

## Verification
A register write can land in the same cycle as a selected pulse. The result then depends on whether the old or the new source, step and prescaler values act on that edge. The bench has a phase that issues control and prescaler writes on the very cycles that carry pulses, cycling through prescaler values below, at and above 2^31 and through zero. A behavioural model applies the write only after it has evaluated the pulse, and the tick, counter and read data are compared with that model on every clock.

// File: rtl/ctm_pkg.sv
// Package: shared constants and types for the core timer prescaler.
// Assumes byte offsets on an 8-bit register address.
package ctm_pkg;
    localparam int ADDR_W    = 8;
    localparam int SRC_BIT   = 8;   // control: source select position
    localparam int STEP_BIT  = 9;   // control: step select position
    localparam logic [ADDR_W-1:0] CTRL_OFS  = 8'h00;
    localparam logic [ADDR_W-1:0] PRESC_OFS = 8'h08;

    typedef struct packed {
        logic step_two;   // 1: counter advances by 2 per tick
        logic src_bus;    // 1: bus pulses drive the rate logic
    } ctm_ctrl_t;
endpackage

// File: rtl/ctm_regs.sv
// Module: ctm_regs
// Holds the control and prescaler registers behind a simple write port
// and a combinational read port. Writes to unmapped offsets are dropped.
// Assumes DATA_W is wider than the highest control bit position.
module ctm_regs
    import ctm_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctm_ctrl_t         ctrl,
    output logic [DATA_W-1:0] presc
);
    logic hit_ctrl;
    logic hit_presc;

    assign hit_ctrl  = wr_en && (wr_addr == AW'(CTRL_OFS));
    assign hit_presc = wr_en && (wr_addr == AW'(PRESC_OFS));

    // Control register: keep only the source and step bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (hit_ctrl) begin
            ctrl.src_bus  <= wr_data[SRC_BIT];
            ctrl.step_two <= wr_data[STEP_BIT];
        end
    end

    // Prescaler register: full-width store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc <= '0;
        end else if (hit_presc) begin
            presc <= wr_data;
        end
    end

    // Read mux: mapped registers in place, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(CTRL_OFS)) begin
            rd_data[SRC_BIT]  = ctrl.src_bus;
            rd_data[STEP_BIT] = ctrl.step_two;
        end else if (rd_addr == AW'(PRESC_OFS)) begin
            rd_data = presc;
        end
    end

    // R3: a write to an unmapped offset leaves both registers unchanged.
    p_unmapped_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_ctrl && !hit_presc) |=> ($stable(ctrl) && $stable(presc)))
        else $error("unmapped write changed a register");
endmodule

// File: rtl/ctm_src_mux.sv
// Module: ctm_src_mux
// Picks the enable pulse of the selected source. Both sources are
// pulses in the block clock domain, so this is a plain enable mux.
module ctm_src_mux #(
    parameter int N_SRC = 2
) (
    input  logic [N_SRC-1:0]         src_pulse,
    input  logic [$clog2(N_SRC)-1:0] sel,
    output logic                     sel_pulse
);
    // Enable select: one pulse input drives the rate logic.
    always_comb begin
        sel_pulse = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == ($clog2(N_SRC))'(i)) sel_pulse = src_pulse[i];
        end
    end
endmodule

// File: rtl/ctm_frac_rate.sv
// Module: ctm_frac_rate
// Fractional rate generator. Each enabled pulse adds 2^(W-1); when the
// sum reaches the prescaler, one tick is issued and the prescaler is
// subtracted. Prescalers at or below 2^(W-1) tick on every pulse; zero
// never ticks. At most one tick per pulse.
module ctm_frac_rate #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DATA_W-1:0] presc,
    output logic              hit,
    output logic              tick
);
    localparam logic [DATA_W:0] HALF = {2'b01, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] acc_nxt;
    logic [DATA_W:0]   sum;
    logic [DATA_W:0]   p_ext;
    logic              unit_rate;
    logic              p_zero;

    assign p_ext     = {1'b0, presc};
    assign sum       = {1'b0, acc} + HALF;
    assign p_zero    = (presc == '0);
    assign unit_rate = !p_zero && (p_ext <= HALF);

    // Next accumulator value and this edge's tick decision.
    always_comb begin
        hit     = 1'b0;
        acc_nxt = acc;
        if (en && !p_zero) begin
            if (unit_rate) begin
                hit     = 1'b1;
                acc_nxt = '0;
            end else if (sum >= p_ext) begin
                hit     = 1'b1;
                acc_nxt = DATA_W'(sum - p_ext);
            end else begin
                acc_nxt = DATA_W'(sum);
            end
        end
    end

    // Accumulator and registered tick strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            acc  <= acc_nxt;
            tick <= hit;
        end
    end

    // R5: a unit-rate prescaler ticks after every enabled pulse.
    p_unit_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !p_zero && ({1'b0, presc} <= HALF)) |=> tick)
        else $error("unit-rate pulse did not tick");

    // R7: a zero prescaler gives no tick and holds the accumulator.
    p_zero_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (presc == '0) |=> (!tick && $stable(acc)))
        else $error("zero prescaler produced activity");
endmodule

// File: rtl/ctm_counter.sv
// Module: ctm_counter
// Free-running counter; advances by one or two on each increment
// request and wraps at its width.
module ctm_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             step_two,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] step_amt;

    assign step_amt = {{(CNT_W-2){1'b0}}, step_two, ~step_two};

    // Counter register: add the step on each increment request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + step_amt;
        end
    end

    // R8: every advance equals the step chosen at that edge.
    p_step_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (count - $past(count) == ($past(step_two) ? CNT_W'(2) : CNT_W'(1))))
        else $error("counter advanced by the wrong step");

    // R7: without a request the counter holds.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count))
        else $error("counter moved without a tick");
endmodule

// File: rtl/ctm_core_timer.sv
// Module: ctm_core_timer
// Top of the core timer prescaler: registers, source mux, fractional
// rate generator and the 64-bit counter. Source pulses are enables in
// the clk domain; register writes act from the edge that stores them.
module ctm_core_timer
    import ctm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xtal_pulse,
    input  logic              bus_pulse,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_waddr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [7:0]        cfg_raddr,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              tick,
    output logic [CNT_W-1:0]  count
);
    ctm_ctrl_t         ctrl;
    logic [DATA_W-1:0] presc;
    logic              sel_pulse;
    logic              hit;

    ctm_regs #(.AW(8), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_addr (cfg_waddr),
        .wr_data (cfg_wdata),
        .rd_addr (cfg_raddr),
        .rd_data (cfg_rdata),
        .ctrl    (ctrl),
        .presc   (presc)
    );

    ctm_src_mux #(.N_SRC(2)) u_mux (
        .src_pulse ({bus_pulse, xtal_pulse}),
        .sel       (ctrl.src_bus),
        .sel_pulse (sel_pulse)
    );

    ctm_frac_rate #(.DATA_W(DATA_W)) u_rate (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sel_pulse),
        .presc (presc),
        .hit   (hit),
        .tick  (tick)
    );

    ctm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (hit),
        .step_two (ctrl.step_two),
        .count    (count)
    );

    // R4: a tick only follows a pulse on the selected source.
    p_tick_needs_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> $past(ctrl.src_bus ? bus_pulse : xtal_pulse))
        else $error("tick without a selected pulse");
endmodule

// File: tb/ctm_core_timer_tb_top.sv
module ctm_core_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_pulse = 1'b0;
    logic        bus_pulse = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        tick;
    logic [63:0] count;

    always #5 clk = ~clk;

    ctm_core_timer dut_i (
        .clk(clk), .rst_n(rst_n), .xtal_pulse(xtal_pulse), .bus_pulse(bus_pulse),
        .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata), .tick(tick), .count(count)
    );

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Behavioural reference state.
    bit              m_src, m_step;
    bit [31:0]       m_p;
    longint unsigned m_acc;
    bit [63:0]       m_cnt;
    bit              m_tick;

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_read(bit [7:0] a);
        if (a == 8'h00) return {22'd0, m_step, m_src, 8'd0};
        if (a == 8'h08) return m_p;
        return 32'd0;
    endfunction

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic cyc(bit xe, bit be, bit we, bit [7:0] wa, bit [31:0] wd);
        bit [7:0] ra;
        bit       en;
        longint unsigned sum;
        ra = 8'(($urandom % 4) * 4);
        xtal_pulse = xe; bus_pulse = be;
        cfg_wr = we; cfg_waddr = wa; cfg_wdata = wd; cfg_raddr = ra;
        @(posedge clk);
        en = m_src ? be : xe;
        m_tick = 1'b0;
        if (en && m_p != 0) begin
            if (m_p <= 32'h8000_0000) begin
                m_tick = 1'b1; m_acc = 0;
            end else begin
                sum = m_acc + 64'h8000_0000;
                if (sum >= longint'(m_p)) begin
                    m_tick = 1'b1; m_acc = sum - longint'(m_p);
                end else m_acc = sum;
            end
        end
        if (m_tick) m_cnt = m_cnt + (m_step ? 64'd2 : 64'd1);
        if (we && wa == 8'h00) begin m_src = wd[8]; m_step = wd[9]; end
        if (we && wa == 8'h08) m_p = wd;
        @(negedge clk);
        check("tick", 64'(tick), 64'(m_tick));
        check("count", count, m_cnt);
        check("rdata", 64'(cfg_rdata), 64'(exp_read(ra)));
    endtask

    task automatic idle_pulses(int n, int pct_x, int pct_b);
        for (int i = 0; i < n; i++)
            cyc(($urandom % 100) < pct_x, ($urandom % 100) < pct_b, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic wr(bit [7:0] a, bit [31:0] d);
        cyc(1'b0, 1'b0, 1'b1, a, d);
    endtask

    initial begin
        bit [31:0] plist [6];
        plist = '{32'h0, 32'h8000_0000, 32'h4000_0000, 32'hC000_0000, 32'hFFFF_FFFF, 32'h9000_0000};
        m_src = 0; m_step = 0; m_p = 0; m_acc = 0; m_cnt = 0; m_tick = 0;
        repeat (4) @(negedge clk);
        // R1: reset state at the ports.
        tag = "R1";
        cfg_raddr = 8'h00; #1 check("ctrl after reset", 64'(cfg_rdata), 64'd0);
        cfg_raddr = 8'h08; #1 check("presc after reset", 64'(cfg_rdata), 64'd0);
        check("tick after reset", 64'(tick), 64'd0);
        check("count after reset", count, 64'd0);
        rst_n = 1'b1;
        idle_pulses(5, 50, 50);
        // R2: only source and step bits stored.
        tag = "R2";
        wr(8'h00, 32'hFFFF_FFFF);
        cfg_raddr = 8'h00; #1 check("ctrl readback", 64'(cfg_rdata), 64'h300);
        wr(8'h00, 32'h0);
        // R3: prescaler readback and unmapped offsets ignored.
        tag = "R3";
        wr(8'h08, 32'h8000_0000);
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h0C, 32'h0000_0300);
        cfg_raddr = 8'h04; #1 check("unmapped read", 64'(cfg_rdata), 64'd0);
        cfg_raddr = 8'h08; #1 check("presc kept", 64'(cfg_rdata), 64'h8000_0000);
        // R5: unit rate on crystal pulses, and below-unit prescaler.
        tag = "R5";
        idle_pulses(40, 60, 0);
        wr(8'h08, 32'h0000_0001);
        idle_pulses(20, 60, 30);
        wr(8'h08, 32'h8000_0000);
        // R4: bus source selected; crystal pulses must do nothing.
        tag = "R4";
        wr(8'h00, 32'h100);
        idle_pulses(30, 100, 0);
        idle_pulses(40, 50, 50);
        wr(8'h00, 32'h000);
        idle_pulses(30, 0, 100);
        // R8: step of two.
        tag = "R8";
        wr(8'h00, 32'h200);
        idle_pulses(40, 70, 20);
        wr(8'h00, 32'h000);
        // R6: fractional rates.
        tag = "R6";
        wr(8'h08, 32'hC000_0000); idle_pulses(60, 100, 0);
        wr(8'h08, 32'hFFFF_FFFF); idle_pulses(60, 70, 0);
        wr(8'h08, 32'h8000_0001); idle_pulses(60, 80, 0);
        wr(8'h00, 32'h300);
        wr(8'h08, 32'hA000_0000); idle_pulses(60, 30, 80);
        wr(8'h00, 32'h000);
        // R7: zero prescaler holds everything.
        tag = "R7";
        wr(8'h08, 32'h0);
        idle_pulses(30, 100, 100);
        // R9: writes landing on pulse cycles.
        tag = "R9";
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 2)
                cyc(1'b1, 1'b1, 1'b1, 8'h00, 32'($urandom % 4) << 8);
            else
                cyc(1'b1, 1'b1, 1'b1, 8'h08, plist[$urandom % 6]);
            idle_pulses(int'($urandom % 3), 50, 50);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(10 * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule